// File: doc/BRIEF.md
# Snooping Write-Back Coherence Controller

This block is the cache controller of one node in a small shared-bus multiprocessor. It holds a direct-mapped array of single-word lines. Each line is tagged with one of three coherence states: Invalid (empty), Shared (clean and read-only) or Exclusive (the only cached copy, writable and dirty). The processor side accepts loads and stores. Hits on a readable line, and stores to a line this node already owns, finish locally. Every other access takes the shared bus through an external arbiter, using one of three commands: a read miss, a write miss (which also acts as an invalidate), or a write-back of a dirty victim.

At the same time the controller watches every command that the other nodes place on the bus. If another node's read miss names a block held here as Exclusive, this node drives the dirty word, raises the owner-supplies line so that memory stays silent, and keeps the line as Shared. If another node's write miss names a block held here, the line is dropped to Invalid, and the dirty word is supplied first when the line was Exclusive. Snoop work wins over the processor: a processor request is not taken while a snoop is on the bus or its reply is pending, and `cpu_busy` shows the stall.

Bus commands are two bits: 00 idle, 01 read miss, 10 write miss, 11 write-back. Addresses are byte addresses. Bits [1:0] select a byte and are passed through. The next bits select the line and the rest form the tag.

Top module: `snoop_wb_cache`

## Requirements
- R1: After reset every line is Invalid, and `bus_req`, `bus_cmd`, `cpu_done`, `cpu_busy` and `snp_supply` are all 0.
- R2: A load to a Shared or Exclusive line with a matching tag raises `cpu_done` for one cycle, with the line's word on `cpu_rdata` and no bus request.
- R3: A load that misses raises `bus_req`, issues command 01 with the request address in the cycle after `bus_gnt`, waits for `fill_valid`, returns `fill_data` with `cpu_done`, and leaves the line Shared.
- R4: A store to a Shared or Invalid line issues command 10 after a grant. Only then does it complete, leaving the line Exclusive and holding the store data.
- R5: No bus command is driven unless `bus_gnt` was high in the previous cycle, and a store that needs the bus does not complete while the grant is withheld.
- R6: A snooped read miss (01) to an Exclusive line gives, in the next cycle, `snp_supply`=1, `snp_valid`=1 and the line's word on `snp_data`, and the line becomes Shared.
- R7: A snooped write miss (10) to an Exclusive line supplies its word as in R6 and invalidates it. To a Shared line it invalidates with no supply.
- R8: A miss whose line holds a different block in Exclusive first issues command 11 with the old block's address and word, and only then issues the miss command.
- R9: A store to an Exclusive line with a matching tag completes with no bus request.
- R10: When a snoop hits, `cpu_busy` is high in the snoop cycle and the following cycle. A processor request presented together with a snoop is accepted only after the snoop response is complete.
- R11: A snooped read miss to a Shared line, or to a line holding another block, produces no supply and no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 for store, 0 for load |
| cpu_addr | input | 32 | Request byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_done | output | 1 | One-cycle completion strobe |
| cpu_rdata | output | 32 | Load result, valid with `cpu_done` |
| cpu_busy | output | 1 | Processor side stalled by snoop work |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_cmd | output | 2 | Command driven by this node |
| bus_addr | output | 32 | Address driven by this node |
| bus_wdata | output | 32 | Write-back word |
| bus_wvalid | output | 1 | Write-back word valid |
| fill_valid | input | 1 | Reply word for this node's read miss is valid |
| fill_data | input | 32 | Reply word from memory or an owner |
| snp_cmd | input | 2 | Command placed on the bus by another node |
| snp_addr | input | 32 | Address placed on the bus by another node |
| snp_supply | output | 1 | This node supplies the block; memory must not reply |
| snp_valid | output | 1 | `snp_data` is valid |
| snp_data | output | 32 | Dirty word supplied by this node |

## Verification
The assertions assume a well-behaved single bus. The arbiter grants only while `bus_req` is high. `snp_cmd` is idle whenever this node holds the grant or is receiving its fill, and `fill_valid` comes only after this node's own read-miss command. The bench plays arbiter, memory and the other nodes. It raises the grant only after seeing `bus_req` and drops it once a command appears. It returns fill data only after a read-miss command, and it presents snoops only while this node is idle on the bus, so every stimulus stays inside those assumptions.

// File: rtl/snoop_wb_pkg.sv
package snoop_wb_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_SHR = 2'b01,
    LS_EXC = 2'b10
  } line_state_e;

  typedef enum logic [1:0] {
    BC_IDLE   = 2'b00,
    BC_RDMISS = 2'b01,
    BC_WRMISS = 2'b10,
    BC_WBACK  = 2'b11
  } bus_cmd_e;

endpackage

// File: rtl/snoop_wb_store.sv
module snoop_wb_store
  import snoop_wb_pkg::*;
#(
  parameter int LINES  = 16,
  parameter int TAG_W  = 26,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  p_idx,
  input  logic              p_we,
  input  line_state_e       p_state,
  input  logic [TAG_W-1:0]  p_tag,
  input  logic [DATA_W-1:0] p_data,
  output line_state_e       p_rd_state,
  output logic [TAG_W-1:0]  p_rd_tag,
  output logic [DATA_W-1:0] p_rd_data,
  input  logic [IDX_W-1:0]  s_idx,
  input  logic              s_we,
  input  line_state_e       s_state,
  output line_state_e       s_rd_state,
  output logic [TAG_W-1:0]  s_rd_tag,
  output logic [DATA_W-1:0] s_rd_data
);

  line_state_e       st_vec  [LINES];
  logic [TAG_W-1:0]  tag_vec [LINES];
  logic [DATA_W-1:0] dat_vec [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic              s_sel, p_sel, st_en;
    line_state_e       st_q, st_d;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] dat_q;

    always_comb begin
      s_sel = s_we && (s_idx == IDX_W'(g));
      p_sel = p_we && (p_idx == IDX_W'(g)) && !s_sel;
      st_en = s_sel || p_sel;
      st_d  = s_sel ? s_state : p_state;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     st_q <= LS_INV;
      else if (st_en) st_q <= st_d;
    end

    always_ff @(posedge clk) begin
      if (p_sel) begin
        tag_q <= p_tag;
        dat_q <= p_data;
      end
    end

    assign st_vec[g]  = st_q;
    assign tag_vec[g] = tag_q;
    assign dat_vec[g] = dat_q;
  end

  assign p_rd_state = st_vec[p_idx];
  assign p_rd_tag   = tag_vec[p_idx];
  assign p_rd_data  = dat_vec[p_idx];
  assign s_rd_state = st_vec[s_idx];
  assign s_rd_tag   = tag_vec[s_idx];
  assign s_rd_data  = dat_vec[s_idx];

  // R8: a valid install never lands on a dirty line that holds another block
  a_r8_no_dirty_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (p_we && p_state != LS_INV && p_rd_state == LS_EXC) |-> (p_rd_tag == p_tag));

endmodule

// File: rtl/snoop_wb_snoop.sv
module snoop_wb_snoop
  import snoop_wb_pkg::*;
#(
  parameter int TAG_W  = 26,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        snp_cmd_i,
  input  logic [TAG_W-1:0]  snp_tag_i,
  input  line_state_e       line_state_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  logic [DATA_W-1:0] line_data_i,
  output logic              s_we_o,
  output line_state_e       s_state_o,
  output logic              busy_o,
  output logic              supply_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);

  logic              match, is_rd, is_wr, hit, supply;
  logic              hit_q, own_q;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    match     = (line_state_i != LS_INV) && (line_tag_i == snp_tag_i);
    is_rd     = (snp_cmd_i == BC_RDMISS);
    is_wr     = (snp_cmd_i == BC_WRMISS);
    supply    = match && (line_state_i == LS_EXC) && (is_rd || is_wr);
    hit       = match && ((is_rd && line_state_i == LS_EXC) || is_wr);
    s_we_o    = hit;
    s_state_o = is_rd ? LS_SHR : LS_INV;
    data_d    = supply ? line_data_i : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      own_q <= 1'b0;
    end else begin
      hit_q <= hit;
      own_q <= supply;
    end
  end

  always_ff @(posedge clk) begin
    if (supply) data_q <= data_d;
  end

  assign busy_o   = hit || hit_q;
  assign supply_o = own_q;
  assign valid_o  = own_q;
  assign data_o   = data_q;

  // R6: a supply always answers a miss command seen on the previous cycle
  a_r6_own_follows_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    supply_o |-> $past(snp_cmd_i == BC_RDMISS || snp_cmd_i == BC_WRMISS));

endmodule

// File: rtl/snoop_wb_proc.sv
module snoop_wb_proc
  import snoop_wb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  input  logic              stall_i,
  output logic              cpu_done_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic [IDX_W-1:0]  p_idx_o,
  input  line_state_e       rd_state_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              p_we_o,
  output line_state_e       p_state_o,
  output logic [TAG_W-1:0]  p_tag_o,
  output logic [DATA_W-1:0] p_data_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_wvalid_o,
  input  logic              fill_valid_i,
  input  logic [DATA_W-1:0] fill_data_i
);

  typedef enum logic [2:0] {
    PS_IDLE, PS_WB_REQ, PS_WB_ISSUE, PS_MISS_REQ, PS_MISS_ISSUE, PS_FILL, PS_DONE
  } pstate_e;

  pstate_e           st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d, cur_addr;
  logic              we_q, we_d;
  logic [DATA_W-1:0] wdata_q, wdata_d, rdata_q, rdata_d;
  logic [TAG_W-1:0]  cur_tag;
  logic              hit;

  always_comb begin
    cur_addr = (st_q == PS_IDLE) ? cpu_addr_i : addr_q;
    cur_tag  = cur_addr[ADDR_W-1 -: TAG_W];
    p_idx_o  = cur_addr[OFF_W +: IDX_W];
    hit      = (rd_state_i != LS_INV) && (rd_tag_i == cur_tag);
  end

  always_comb begin
    st_d      = st_q;
    addr_d    = addr_q;
    we_d      = we_q;
    wdata_d   = wdata_q;
    rdata_d   = rdata_q;
    p_we_o    = 1'b0;
    p_state_o = LS_INV;
    p_tag_o   = cur_tag;
    p_data_o  = wdata_q;
    unique case (st_q)
      PS_IDLE: begin
        if (cpu_req_i && !stall_i) begin
          addr_d  = cpu_addr_i;
          we_d    = cpu_we_i;
          wdata_d = cpu_wdata_i;
          if (!cpu_we_i && hit) begin
            rdata_d = rd_data_i;
            st_d    = PS_DONE;
          end else if (cpu_we_i && hit && rd_state_i == LS_EXC) begin
            p_we_o    = 1'b1;
            p_state_o = LS_EXC;
            p_data_o  = cpu_wdata_i;
            st_d      = PS_DONE;
          end else if (!hit && rd_state_i == LS_EXC) begin
            st_d = PS_WB_REQ;
          end else begin
            st_d = PS_MISS_REQ;
          end
        end
      end
      PS_WB_REQ: begin
        if (rd_state_i != LS_EXC) st_d = PS_MISS_REQ;
        else if (bus_gnt_i)       st_d = PS_WB_ISSUE;
      end
      PS_WB_ISSUE: begin
        p_we_o    = 1'b1;
        p_state_o = LS_INV;
        p_tag_o   = rd_tag_i;
        p_data_o  = rd_data_i;
        st_d      = PS_MISS_REQ;
      end
      PS_MISS_REQ: begin
        if (bus_gnt_i) st_d = PS_MISS_ISSUE;
      end
      PS_MISS_ISSUE: begin
        if (we_q) begin
          p_we_o    = 1'b1;
          p_state_o = LS_EXC;
          st_d      = PS_DONE;
        end else begin
          st_d = PS_FILL;
        end
      end
      PS_FILL: begin
        if (fill_valid_i) begin
          p_we_o    = 1'b1;
          p_state_o = LS_SHR;
          p_data_o  = fill_data_i;
          rdata_d   = fill_data_i;
          st_d      = PS_DONE;
        end
      end
      PS_DONE: st_d = PS_IDLE;
      default: st_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PS_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    addr_q  <= addr_d;
    we_q    <= we_d;
    wdata_q <= wdata_d;
    rdata_q <= rdata_d;
  end

  always_comb begin
    bus_cmd_o    = BC_IDLE;
    bus_addr_o   = '0;
    bus_wdata_o  = '0;
    bus_wvalid_o = 1'b0;
    if (st_q == PS_WB_ISSUE) begin
      bus_cmd_o    = BC_WBACK;
      bus_addr_o   = {rd_tag_i, addr_q[OFF_W +: IDX_W], addr_q[OFF_W-1:0]};
      bus_wdata_o  = rd_data_i;
      bus_wvalid_o = 1'b1;
    end else if (st_q == PS_MISS_ISSUE) begin
      bus_cmd_o  = we_q ? BC_WRMISS : BC_RDMISS;
      bus_addr_o = addr_q;
    end
  end

  assign bus_req_o   = (st_q == PS_WB_REQ) || (st_q == PS_WB_ISSUE) ||
                       (st_q == PS_MISS_REQ) || (st_q == PS_MISS_ISSUE);
  assign cpu_done_o  = (st_q == PS_DONE);
  assign cpu_rdata_o = rdata_q;

  // R5: a command on the bus needs the grant from the previous cycle
  a_r5_issue_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_o != BC_IDLE) |-> $past(bus_gnt_i));

  // R2: completion is a single-cycle strobe
  a_r2_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done_o |=> !cpu_done_o);

  // R3: an awaited fill finishes the load on the next cycle
  a_r3_fill_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_FILL && fill_valid_i) |=> cpu_done_o);

  // R4: a store completes right after its write-miss command
  a_r4_store_after_wrmiss: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_o == BC_WRMISS) |=> cpu_done_o);

endmodule

// File: rtl/snoop_wb_cache.sv
module snoop_wb_cache
  import snoop_wb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_busy,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_wvalid,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_supply,
  output logic              snp_valid,
  output logic [DATA_W-1:0] snp_data
);

  localparam int IDX_W = $clog2(LINES);
  localparam int OFF_W = $clog2(DATA_W / 8);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [1:0] rsync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  logic [IDX_W-1:0]  p_idx;
  logic              p_we, s_we, snp_busy, stall;
  line_state_e       p_state, p_rd_state, s_state, s_rd_state;
  logic [TAG_W-1:0]  p_tag, p_rd_tag, s_rd_tag;
  logic [DATA_W-1:0] p_data, p_rd_data, s_rd_data;
  logic              unused_snp_offset;

  assign unused_snp_offset = ^snp_addr[OFF_W-1:0];
  assign stall    = (snp_cmd != BC_IDLE) || snp_busy;
  assign cpu_busy = snp_busy;

  snoop_wb_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) store_i (
    .clk(clk), .rst_n(rst_sync_n),
    .p_idx(p_idx), .p_we(p_we), .p_state(p_state), .p_tag(p_tag), .p_data(p_data),
    .p_rd_state(p_rd_state), .p_rd_tag(p_rd_tag), .p_rd_data(p_rd_data),
    .s_idx(snp_addr[OFF_W +: IDX_W]), .s_we(s_we), .s_state(s_state),
    .s_rd_state(s_rd_state), .s_rd_tag(s_rd_tag), .s_rd_data(s_rd_data)
  );

  snoop_wb_snoop #(.TAG_W(TAG_W), .DATA_W(DATA_W)) snoop_i (
    .clk(clk), .rst_n(rst_sync_n),
    .snp_cmd_i(snp_cmd), .snp_tag_i(snp_addr[ADDR_W-1 -: TAG_W]),
    .line_state_i(s_rd_state), .line_tag_i(s_rd_tag), .line_data_i(s_rd_data),
    .s_we_o(s_we), .s_state_o(s_state), .busy_o(snp_busy),
    .supply_o(snp_supply), .valid_o(snp_valid), .data_o(snp_data)
  );

  snoop_wb_proc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) proc_i (
    .clk(clk), .rst_n(rst_sync_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .stall_i(stall), .cpu_done_o(cpu_done), .cpu_rdata_o(cpu_rdata),
    .p_idx_o(p_idx), .rd_state_i(p_rd_state), .rd_tag_i(p_rd_tag), .rd_data_i(p_rd_data),
    .p_we_o(p_we), .p_state_o(p_state), .p_tag_o(p_tag), .p_data_o(p_data),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_wvalid_o(bus_wvalid),
    .fill_valid_i(fill_valid), .fill_data_i(fill_data)
  );

endmodule

// File: tb/snoop_wb_cache_tb_top.sv
module snoop_wb_cache_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_done, cpu_busy;
  logic [31:0] cpu_rdata;
  logic        bus_req, bus_gnt = 1'b0;
  logic [1:0]  bus_cmd;
  logic [31:0] bus_addr, bus_wdata;
  logic        bus_wvalid;
  logic        fill_valid = 1'b0;
  logic [31:0] fill_data = '0;
  logic [1:0]  snp_cmd = 2'b00;
  logic [31:0] snp_addr = '0;
  logic        snp_supply, snp_valid;
  logic [31:0] snp_data;

  always #10 clk = ~clk;

  snoop_wb_cache dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .cpu_busy(cpu_busy),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wvalid(bus_wvalid),
    .fill_valid(fill_valid), .fill_data(fill_data),
    .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_supply(snp_supply), .snp_valid(snp_valid), .snp_data(snp_data)
  );

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  ended    = 1'b0;

  logic [31:0] mem   [64];
  bit          mem_w [64];

  function automatic logic [31:0] mem_rd(logic [31:0] a);
    return mem_w[a[7:2]] ? mem[a[7:2]] : {16'hC0DE, 8'h00, a[7:0]};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // processor access; this task also acts as arbiter and memory
  task automatic cpu_op(input logic we, input logic [31:0] addr, input logic [31:0] wdata,
                        input int hold, output logic [3:0] seq, output logic [31:0] rd,
                        output bit early, output bit done);
    int  waited = 0;
    bit  granted = 1'b0;
    bit  req_seen = 1'b0;
    seq = 4'h0; rd = '0; early = 1'b0; done = 1'b0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wdata;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (cpu_done) begin
        rd = cpu_rdata; done = 1'b1;
        if (req_seen && !granted) early = 1'b1;
        break;
      end
      if (bus_cmd != 2'b00) begin
        seq = {seq[1:0], bus_cmd};
        if (!granted) early = 1'b1;
        bus_gnt = 1'b0;
        if (bus_cmd == 2'b11) begin
          mem[bus_addr[7:2]] = bus_wdata; mem_w[bus_addr[7:2]] = 1'b1;
        end
        if (bus_cmd == 2'b01) begin
          fill_valid = 1'b1; fill_data = mem_rd(bus_addr);
        end
      end else if (bus_req) begin
        req_seen = 1'b1;
        if (waited >= hold) begin bus_gnt = 1'b1; granted = 1'b1; end
        else waited++;
      end
    end
    cpu_req = 1'b0; fill_valid = 1'b0; bus_gnt = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [31:0] addr, output bit busy0,
                       output bit own, output bit vld, output logic [31:0] data, output bit busy1);
    @(negedge clk);
    snp_cmd = cmd; snp_addr = addr;
    #1 busy0 = cpu_busy;
    @(negedge clk);
    snp_cmd = 2'b00;
    own = snp_supply; vld = snp_valid; data = snp_data; busy1 = cpu_busy;
    if (own) begin mem[addr[7:2]] = data; mem_w[addr[7:2]] = 1'b1; end
  endtask

  // {we, addr, wdata, expected last two bus commands, expected load data}
  localparam logic [100:0] VEC [9] = '{
    {1'b0, 32'h0000_0040, 32'h0, 4'b0001, 32'hC0DE_0040},  // R3 load miss
    {1'b0, 32'h0000_0040, 32'h0, 4'b0000, 32'hC0DE_0040},  // R2 Shared hit
    {1'b1, 32'h0000_0040, 32'hDEAD_0001, 4'b0010, 32'h0},  // R4 store to Shared
    {1'b1, 32'h0000_0040, 32'hDEAD_0002, 4'b0000, 32'h0},  // R9 store to Exclusive
    {1'b0, 32'h0000_0040, 32'h0, 4'b0000, 32'hDEAD_0002},  // R9 local data
    {1'b0, 32'h0000_0080, 32'h0, 4'b1101, 32'hC0DE_0080},  // R8 dirty collision
    {1'b0, 32'h0000_0040, 32'h0, 4'b0001, 32'hDEAD_0002},  // R8 written-back word
    {1'b1, 32'h0000_0104, 32'h0000_1234, 4'b0010, 32'h0},  // R4 store to Invalid
    {1'b0, 32'h0000_0104, 32'h0, 4'b0000, 32'h0000_1234}   // R2 Exclusive hit
  };

  function automatic string vec_req(int i);
    case (i)
      0: return "R3";
      1, 8: return "R2";
      2, 7: return "R4";
      3, 4: return "R9";
      default: return "R8";
    endcase
  endfunction

  initial begin
    #(20 * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [3:0]  seq;
    logic [31:0] rd, sdata;
    bit early, done, b0, b1, own, vld;
    for (int i = 0; i < 64; i++) begin mem[i] = '0; mem_w[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state at the ports
    check(bus_req == 1'b0, "R1", {31'd0, bus_req}, 32'd0);
    check(bus_cmd == 2'b00, "R1", {30'd0, bus_cmd}, 32'd0);
    check(cpu_done == 1'b0, "R1", {31'd0, cpu_done}, 32'd0);
    check(cpu_busy == 1'b0, "R1", {31'd0, cpu_busy}, 32'd0);
    check(snp_supply == 1'b0, "R1", {31'd0, snp_supply}, 32'd0);

    for (int i = 0; i < 9; i++) begin
      cpu_op(VEC[i][100], VEC[i][99:68], VEC[i][67:36], 0, seq, rd, early, done);
      check(done && seq == VEC[i][35:32], vec_req(i), {27'd0, done, seq}, {28'd1, VEC[i][35:32]});
      if (!VEC[i][100]) check(rd == VEC[i][31:0], vec_req(i), rd, VEC[i][31:0]);
    end

    // R6 snooped read miss on the Exclusive line at 0x104
    snoop(2'b01, 32'h0000_0104, b0, own, vld, sdata, b1);
    check(own && vld, "R6", {30'd0, own, vld}, 32'd3);
    check(sdata == 32'h0000_1234, "R6", sdata, 32'h0000_1234);
    check(b0 && b1, "R10", {30'd0, b0, b1}, 32'd3);
    cpu_op(1'b1, 32'h0000_0104, 32'h0000_5678, 0, seq, rd, early, done);
    check(seq == 4'b0010, "R6", {28'd0, seq}, 32'd2);  // now Shared, so store misses

    // R7 snooped write miss on Exclusive: supply then invalidate
    snoop(2'b10, 32'h0000_0104, b0, own, vld, sdata, b1);
    check(own && sdata == 32'h0000_5678, "R7", sdata, 32'h0000_5678);
    cpu_op(1'b0, 32'h0000_0104, 32'h0, 0, seq, rd, early, done);
    check(seq == 4'b0001, "R7", {28'd0, seq}, 32'd1);
    check(rd == 32'h0000_5678, "R7", rd, 32'h0000_5678);

    // R7 snooped write miss on Shared: silent invalidate
    snoop(2'b10, 32'h0000_0040, b0, own, vld, sdata, b1);
    check(!own && !vld, "R7", {30'd0, own, vld}, 32'd0);
    check(b0, "R10", {31'd0, b0}, 32'd1);
    cpu_op(1'b0, 32'h0000_0040, 32'h0, 0, seq, rd, early, done);
    check(seq == 4'b0001 && rd == 32'hDEAD_0002, "R7", rd, 32'hDEAD_0002);

    // R11 snooped read miss on Shared and on another block
    snoop(2'b01, 32'h0000_0040, b0, own, vld, sdata, b1);
    check(!own && !b0 && !b1, "R11", {29'd0, own, b0, b1}, 32'd0);
    snoop(2'b01, 32'h0000_0080, b0, own, vld, sdata, b1);
    check(!own && !b0, "R11", {30'd0, own, b0}, 32'd0);

    // R10 snoop wins over a simultaneous processor request
    cpu_op(1'b1, 32'h0000_0104, 32'h0000_9999, 0, seq, rd, early, done);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 32'h0000_0040;
    snp_cmd = 2'b01; snp_addr = 32'h0000_0104;
    @(negedge clk);
    snp_cmd = 2'b00;
    check(snp_supply && snp_data == 32'h0000_9999 && !cpu_done, "R10", snp_data, 32'h0000_9999);
    if (snp_supply) begin mem[1] = snp_data; mem_w[1] = 1'b1; end
    begin
      int n = 1;
      while (!cpu_done && n < 10) begin @(negedge clk); n++; end
      check(n == 3, "R10", n, 32'd3);
      check(cpu_rdata == 32'hDEAD_0002, "R2", cpu_rdata, 32'hDEAD_0002);
    end
    cpu_req = 1'b0;

    // R5 store held off by a withheld grant
    cpu_op(1'b1, 32'h0000_0040, 32'h0000_AAAA, 6, seq, rd, early, done);
    check(!early && done, "R5", {30'd0, early, done}, 32'd1);
    check(seq == 4'b0010, "R5", {28'd0, seq}, 32'd2);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule